// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the software-facing register file of a DMA channel. It holds four 32-bit words behind a simple register bus: a control/status word, a transfer address pointer, and two general storage words. It does not move data. It turns register writes and a device interrupt input into three outputs: an interrupt request, a one-cycle reset pulse for the attached peripheral, and a level that enables the DMA engine.

The control/status word keeps a fixed version code in its top bits and protects a read-only field. It records whether an interrupt is pending, whether interrupts are enabled and whether the pointer has been loaded. The pointer word is loaded by software and then advanced by the data mover through a side-band port, by the byte length of each finished transfer. A build parameter selects a doubled address window, in which offsets above the register range read as zero and ignore writes.

Two small state machines drive the outputs. The interrupt machine has the states IRQ_QUIET and IRQ_ASSERTED. It moves from IRQ_QUIET to IRQ_ASSERTED when the next pending and enable bits are both set, and it moves back when either of them is clear. The enable machine has the states XFER_OFF and XFER_ON. It goes from XFER_OFF to XFER_ON on a control write that sets the enable bit, and from XFER_ON to XFER_OFF on a control write that clears it.

Top module: `dmactl_regs`

## Requirements
- R1: After reset the control word reads 0xA0000000, words 1 to 3 read zero, and bus_rdata, irq_out, periph_rst and dma_en_out are all 0.
- R2: The word is selected by bits [3:2] of bus_addr, and bits [1:0] and bit 4 are ignored. A read strobe places the selected word on bus_rdata at the next clock edge. A read returns the value as it was before a write made in the same cycle.
- R3: A control write keeps the stored bits under mask 0xFE000007 unchanged, takes every other bit from the write data, and forces bits 31 and 29 to 1.
- R4: A control write with bit 7 set makes periph_rst high for exactly the following cycle.
- R5: On a control write without bit 7, a set bit 6 is stored as 0. A write of exactly zero stores bit 6 as 1.
- R6: A rising edge on dev_irq sets the pending bit 0. A falling edge clears it. irq_out follows pending only while the enable bit 4 is set.
- R7: A control write that sets bit 4 raises irq_out when pending is set. A control write that clears bit 4 lowers irq_out.
- R8: dma_en_out rises on a control write that sets bit 9 and falls on a control write that clears bit 9.
- R9: A write to word 1 stores the data and sets bit 26 of the control word. Bit 26 then stays set until reset.
- R10: An advance strobe adds adv_len to word 1. When a write to word 1 and an advance fall in the same cycle, the write wins.
- R11: Words 2 and 3 store and return whatever is written to them.
- R12: With EXT_WINDOW=1, offsets above 0x1F read as zero, and writes to them change no state and raise no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dev_irq | input | 1 | Interrupt level from the device |
| adv_valid | input | 1 | A transfer has completed; advance the pointer |
| adv_len | input | LEN_W | Byte length of the completed transfer |
| irq_out | output | 1 | Interrupt request |
| periph_rst | output | 1 | One-cycle reset pulse for the peripheral |
| dma_en_out | output | 1 | DMA engine enable level |

## Verification
The assertions assume that every access is a full 32-bit word. They also assume that dev_irq is synchronous to clk, and that a control write with bit 7 set is never followed by a second such write in the next cycle. The stimulus keeps to these limits by driving all inputs at the falling edge and by leaving at least one idle cycle between strobes. The stimulus also triggers the collision between a pointer write and an advance, and it reaches the two window boundaries, the last word below 0x20 and the aliased control offset above it.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;
    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] VERSION_CODE = 32'hA000_0000;
    localparam logic [WORD_W-1:0] LOCKED_MASK  = 32'hFE00_0007;
    localparam int B_PEND   = 0;
    localparam int B_IRQEN  = 4;
    localparam int B_DRAIN  = 6;
    localparam int B_PRST   = 7;
    localparam int B_XFEREN = 9;
    localparam int B_LOADED = 26;

    typedef enum logic {IRQ_QUIET, IRQ_ASSERTED} irq_state_t;
    typedef enum logic {XFER_OFF, XFER_ON} xfer_state_t;
endpackage

// File: rtl/dmactl_decode.sv
module dmactl_decode #(
    parameter int ADDR_W     = 6,
    parameter bit EXT_WINDOW = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              in_range,
    output logic [1:0]        idx,
    output logic              csr_wr,
    output logic              ptr_wr,
    output logic [1:0]        store_wr
);
    logic [ADDR_W-6:0] hi_bits;
    logic              unused_addr;

    assign hi_bits     = addr[ADDR_W-1:5];
    assign unused_addr = ^{addr[4], addr[1:0]};
    assign idx         = addr[3:2];
    assign in_range    = !(EXT_WINDOW && (hi_bits != '0));

    always_comb begin
        csr_wr   = wr && in_range && (idx == 2'd0);
        ptr_wr   = wr && in_range && (idx == 2'd1);
        store_wr = '0;
        if (wr && in_range && idx[1]) store_wr[idx[0]] = 1'b1;
    end
endmodule

// File: rtl/dmactl_csr.sv
module dmactl_csr
    import dmactl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              set_loaded,
    input  logic              dev_irq,
    output logic [WORD_W-1:0] csr_q,
    output logic              irq_out,
    output logic              periph_rst,
    output logic              dma_en_out
);
    logic [WORD_W-1:0] csr_n, wval;
    logic              dev_prev, dev_rise, dev_fall, prst_cmd, pulse_q;
    irq_state_t        irq_st, irq_st_n;
    xfer_state_t       xfer_st, xfer_st_n;

    assign dev_rise = dev_irq && !dev_prev;
    assign dev_fall = !dev_irq && dev_prev;
    assign prst_cmd = csr_wr && wdata[B_PRST];

    always_comb begin
        wval = wdata;
        if (!wdata[B_PRST]) begin
            if (wdata[B_DRAIN])      wval[B_DRAIN] = 1'b0;
            else if (wdata == '0)    wval[B_DRAIN] = 1'b1;
        end
        csr_n = csr_q;
        if (csr_wr) csr_n = (csr_q & LOCKED_MASK) | (wval & ~LOCKED_MASK) | VERSION_CODE;
        if (set_loaded) csr_n[B_LOADED] = 1'b1;
        if (dev_rise)                      csr_n[B_PEND] = 1'b1;
        else if (dev_fall && csr_q[B_PEND]) csr_n[B_PEND] = 1'b0;
    end

    always_comb begin
        irq_st_n = irq_st;
        unique case (irq_st)
            IRQ_QUIET:    if (csr_n[B_PEND] && csr_n[B_IRQEN])    irq_st_n = IRQ_ASSERTED;
            IRQ_ASSERTED: if (!(csr_n[B_PEND] && csr_n[B_IRQEN])) irq_st_n = IRQ_QUIET;
        endcase
        xfer_st_n = xfer_st;
        unique case (xfer_st)
            XFER_OFF: if (csr_wr && csr_n[B_XFEREN])  xfer_st_n = XFER_ON;
            XFER_ON:  if (csr_wr && !csr_n[B_XFEREN]) xfer_st_n = XFER_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_q    <= VERSION_CODE;
            dev_prev <= 1'b0;
            pulse_q  <= 1'b0;
            irq_st   <= IRQ_QUIET;
            xfer_st  <= XFER_OFF;
        end else begin
            csr_q    <= csr_n;
            dev_prev <= dev_irq;
            pulse_q  <= prst_cmd;
            irq_st   <= irq_st_n;
            xfer_st  <= xfer_st_n;
        end
    end

    always_comb begin
        irq_out    = (irq_st == IRQ_ASSERTED);
        dma_en_out = (xfer_st == XFER_ON);
        periph_rst = pulse_q;
    end

    a_r4_pulse_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        periph_rst |-> $past(csr_wr));
    a_r6_rise_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rise |=> csr_q[B_PEND]);
    a_r3_version_forced: assert property (@(posedge clk) disable iff (!rst_n)
        csr_q[31] && csr_q[29] && !csr_q[30]);
    a_r8_enable_tracks_bit: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en_out == csr_q[B_XFEREN]);
    a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (csr_q[B_PEND] && csr_q[B_IRQEN]));
endmodule

// File: rtl/dmactl_ptr.sv
module dmactl_ptr
    import dmactl_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              adv_valid,
    input  logic [LEN_W-1:0]  adv_len,
    output logic [WORD_W-1:0] ptr_q
);
    localparam int PAD_W = WORD_W - LEN_W;

    always_ff @(posedge clk) begin
        if (!rst_n)         ptr_q <= '0;
        else if (wr)        ptr_q <= wdata;
        else if (adv_valid) ptr_q <= ptr_q + {{PAD_W{1'b0}}, adv_len};
    end

    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ptr_q == $past(wdata));
endmodule

// File: rtl/dmactl_store.sv
module dmactl_store
    import dmactl_pkg::*;
#(
    parameter int NUM = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM-1:0]               wr_sel,
    input  logic [WORD_W-1:0]            wdata,
    output logic [NUM-1:0][WORD_W-1:0]   words_q
);
    for (genvar g = 0; g < NUM; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)         words_q[g] <= '0;
            else if (wr_sel[g]) words_q[g] <= wdata;
        end
    end

    a_r11_one_hot_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
endmodule

// File: rtl/dmactl_regs.sv
module dmactl_regs
    import dmactl_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter bit EXT_WINDOW = 1'b0,
    parameter int LEN_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              dev_irq,
    input  logic              adv_valid,
    input  logic [LEN_W-1:0]  adv_len,
    output logic              irq_out,
    output logic              periph_rst,
    output logic              dma_en_out
);
    localparam int STORE_N = 2;

    logic                              in_range, csr_wr, ptr_wr;
    logic [1:0]                        idx;
    logic [STORE_N-1:0]                store_wr;
    logic [WORD_W-1:0]                 csr_q, ptr_q, sel_word;
    logic [STORE_N-1:0][WORD_W-1:0]    store_q;

    dmactl_decode #(.ADDR_W(ADDR_W), .EXT_WINDOW(EXT_WINDOW)) u_dec (
        .addr(bus_addr), .wr(bus_wr), .in_range(in_range), .idx(idx),
        .csr_wr(csr_wr), .ptr_wr(ptr_wr), .store_wr(store_wr));

    dmactl_csr u_csr (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .wdata(bus_wdata),
        .set_loaded(ptr_wr), .dev_irq(dev_irq), .csr_q(csr_q),
        .irq_out(irq_out), .periph_rst(periph_rst), .dma_en_out(dma_en_out));

    dmactl_ptr #(.LEN_W(LEN_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .wr(ptr_wr), .wdata(bus_wdata),
        .adv_valid(adv_valid), .adv_len(adv_len), .ptr_q(ptr_q));

    dmactl_store #(.NUM(STORE_N)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_sel(store_wr), .wdata(bus_wdata),
        .words_q(store_q));

    always_comb begin
        unique case (idx)
            2'd0: sel_word = csr_q;
            2'd1: sel_word = ptr_q;
            2'd2: sel_word = store_q[0];
            2'd3: sel_word = store_q[1];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= in_range ? sel_word : '0;
    end

    a_r9_loaded_set: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr |=> csr_q[B_LOADED]);
    a_r9_loaded_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(csr_q[B_LOADED]) |-> csr_q[B_LOADED]);
    a_r12_outside_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_range) |=> bus_rdata == '0);
endmodule

// File: tb/dmactl_regs_test.sv
module dmactl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dev_irq = 1'b0, adv_valid = 1'b0;
    logic [15:0] adv_len = '0;
    logic        irq_out, periph_rst, dma_en_out;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    dmactl_regs #(.ADDR_W(6), .EXT_WINDOW(1'b1), .LEN_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_irq(dev_irq), .adv_valid(adv_valid), .adv_len(adv_len),
        .irq_out(irq_out), .periph_rst(periph_rst), .dma_en_out(dma_en_out));

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    // monitor: compares registered read data against the scoreboard queue
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) check("scoreboard underflow", 32'd1, 32'd0);
            else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic advance(logic [15:0] len, bit with_wr, logic [31:0] d);
        @(negedge clk);
        adv_valid = 1'b1; adv_len = len;
        if (with_wr) begin bus_wr = 1'b1; bus_addr = 6'h04; bus_wdata = d; end
        @(negedge clk);
        adv_valid = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic set_dev(logic v);
        @(negedge clk);
        dev_irq = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata", bus_rdata, 32'h0);
        check("R1 irq_out", {31'd0, irq_out}, 32'd0);
        check("R1 periph_rst", {31'd0, periph_rst}, 32'd0);
        check("R1 dma_en_out", {31'd0, dma_en_out}, 32'd0);
        rd(6'h00, 32'hA000_0000, "R1 control word");
        rd(6'h04, 32'h0, "R1 word1");
        rd(6'h08, 32'h0, "R1 word2");
        rd(6'h0C, 32'h0, "R1 word3");

        // R3 / R4 / R8: all-ones control write
        wr(6'h00, 32'hFFFF_FFFF);
        check("R4 pulse high", {31'd0, periph_rst}, 32'd1);
        check("R8 enable rises", {31'd0, dma_en_out}, 32'd1);
        @(negedge clk);
        check("R4 pulse one cycle", {31'd0, periph_rst}, 32'd0);
        rd(6'h00, 32'hA1FF_FFF8, "R3 locked mask and version");

        // R5: drain bit cleared; R8 falls
        wr(6'h00, 32'h0000_0040);
        check("R8 enable falls", {31'd0, dma_en_out}, 32'd0);
        check("R5 no pulse without bit7", {31'd0, periph_rst}, 32'd0);
        rd(6'h00, 32'hA000_0000, "R5 drain cleared");
        wr(6'h00, 32'h0);
        rd(6'h00, 32'hA000_0040, "R5 zero write sets drain");

        // R6 / R7
        wr(6'h00, 32'h0000_0010);
        check("R6 irq low before event", {31'd0, irq_out}, 32'd0);
        set_dev(1'b1);
        check("R6 irq raised on rise", {31'd0, irq_out}, 32'd1);
        rd(6'h00, 32'hA000_0011, "R6 pending set");
        wr(6'h00, 32'h0000_0200);
        check("R7 write clears enable lowers irq", {31'd0, irq_out}, 32'd0);
        check("R8 enable rises again", {31'd0, dma_en_out}, 32'd1);
        rd(6'h00, 32'hA000_0201, "R7 pending kept");
        wr(6'h00, 32'h0000_0210);
        check("R7 write sets enable raises irq", {31'd0, irq_out}, 32'd1);
        set_dev(1'b0);
        check("R6 irq lowered on fall", {31'd0, irq_out}, 32'd0);
        rd(6'h00, 32'hA000_0210, "R6 pending cleared");
        wr(6'h00, 32'h0000_0200);
        set_dev(1'b1);
        check("R6 irq masked when disabled", {31'd0, irq_out}, 32'd0);
        rd(6'h00, 32'hA000_0201, "R6 pending set while masked");
        set_dev(1'b0);
        rd(6'h00, 32'hA000_0200, "R6 pending cleared while masked");

        // R9 / R10
        wr(6'h04, 32'h0000_1000);
        rd(6'h00, 32'hA400_0200, "R9 loaded bit");
        rd(6'h04, 32'h0000_1000, "R9 pointer stored");
        advance(16'h0020, 1'b0, 32'h0);
        rd(6'h04, 32'h0000_1020, "R10 advance 0x20");
        advance(16'h0003, 1'b0, 32'h0);
        rd(6'h04, 32'h0000_1023, "R10 advance 3");
        advance(16'h0008, 1'b1, 32'h0000_5000);
        rd(6'h04, 32'h0000_5000, "R10 write wins");

        // R11 / R2
        wr(6'h08, 32'hDEAD_BEEF);
        wr(6'h0C, 32'h1234_5678);
        rd(6'h08, 32'hDEAD_BEEF, "R11 word2");
        rd(6'h0C, 32'h1234_5678, "R11 word3");
        rd(6'h18, 32'hDEAD_BEEF, "R2 alias bit4");
        rd(6'h1F, 32'h1234_5678, "R2 low bits ignored at window edge");
        @(negedge clk);
        bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 6'h08; bus_wdata = 32'h0BAD_F00D;
        exp_q.push_back(32'hDEAD_BEEF); tag_q.push_back("R2 read before same-cycle write");
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        rd(6'h08, 32'h0BAD_F00D, "R11 word2 rewritten");

        // R12
        wr(6'h28, 32'hFFFF_0000);
        rd(6'h08, 32'h0BAD_F00D, "R12 outside write ignored");
        rd(6'h28, 32'h0, "R12 outside read zero");
        wr(6'h20, 32'h0000_0280);
        check("R12 no pulse from outside", {31'd0, periph_rst}, 32'd0);
        rd(6'h20, 32'h0, "R12 control alias reads zero");
        rd(6'h00, 32'hA400_0200, "R12 control word untouched");

        repeat (3) @(negedge clk);
        check("scoreboard drained", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule